// File: doc/BRIEF.md
# Epoch-Tagged Fetch Redirect Controller

This block owns the fetch program counter of an in-order pipeline and the epoch tags that separate correct-path work from wrong-path work. Two stages may correct the fetch stream. The decode stage resolves targets it can compute early. The execute stage resolves conditional branches, and its decisions are final. Each correcting stage keeps its own epoch counter and advances it whenever it redirects. Fetch stamps every instruction with its copies of both counters. A stage that later sees a stale stamp treats the instruction as wrong-path.

Each cycle the block takes at most one redirect request from decode and one from execute. Each request carries a target and the tags of the instruction that raised it. The block returns a kill decision to each stage for the instruction that stage holds. An execute correction always wins over a younger decode correction, whether the two arrive in the same cycle or the decode one arrives a cycle later. The PC and the epoch copies live in the same register bank and change on the same clock edge, so fetch never sees a new PC with an old tag.

Top module: `epoch_redirect_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `fetch_pc` equals `RESET_PC`, both fetch tags are zero and `redir_src` is 0.
- R2: In a cycle with no accepted redirect, `fetch_pc` advances by `STEP` (default 4) at the next edge if `fetch_en` is high, and holds if it is low. `redir_src` then reads 0.
- R3: An execute request (`exe_valid`, `exe_mispredict`, and `exe_etag` equal to the current execute epoch) sets `fetch_pc` to `exe_target` at the next edge and increments `fetch_etag` modulo 2^EPOCH_W. `redir_src` then reads 2.
- R4: An accepted decode request sets `fetch_pc` to `dec_target` at the next edge and increments `fetch_dtag` while `fetch_etag` holds. `redir_src` then reads 1.
- R5: When valid execute and decode requests come in the same cycle, only the execute one takes effect. `fetch_dtag` is unchanged.
- R6: `dec_kill` is high in the same cycle when `dec_valid` is high and either `dec_etag` differs from decode's copy of the execute epoch or `dec_dtag` differs from the decode epoch. A killed decode request has no effect on the PC or the tags.
- R7: In the cycle after an execute redirect, a decode instruction that carries the pre-redirect execute tag is killed and its request is dropped.
- R8: A decode redirect followed one cycle later by an execute redirect leaves `fetch_pc` at the execute target.
- R9: `exe_kill` is high in the same cycle when `exe_valid` is high and `exe_etag` differs from the execute epoch. A killed execute request has no effect.
- R10: A redirect is applied whether or not `fetch_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Fetch consumed the current PC this cycle |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_mispredict | input | 1 | Decode found a wrong predicted target |
| dec_target | input | PC_W | Decode's corrected target |
| dec_etag | input | EPOCH_W | Execute-epoch stamp of the decode instruction |
| dec_dtag | input | EPOCH_W | Decode-epoch stamp of the decode instruction |
| exe_valid | input | 1 | Execute holds an instruction |
| exe_mispredict | input | 1 | Execute found a wrong predicted target |
| exe_target | input | PC_W | Execute's corrected target |
| exe_etag | input | EPOCH_W | Execute-epoch stamp of the execute instruction |
| fetch_pc | output | PC_W | Address to fetch |
| fetch_etag | output | EPOCH_W | Execute-epoch stamp for the fetched instruction |
| fetch_dtag | output | EPOCH_W | Decode-epoch stamp for the fetched instruction |
| dec_kill | output | 1 | Decode instruction is wrong-path |
| exe_kill | output | 1 | Execute instruction is wrong-path, to be poisoned |
| redir_src | output | 2 | Source of the last applied redirect: 0 none, 1 decode, 2 execute |

## Verification
The bench drives directed sequences first. These are plain sequential fetch with stalls, a lone decode correction, a lone execute correction, a collision of both in one cycle, execute followed by a stale decode request, and decode followed by execute. Each sequence isolates one ordering rule, so a wrong priority or a missed epoch update shows up as a wrong PC or tag on a specific cycle. A long run then follows in which the stamps are drawn partly from the current epochs and partly stale. This tells apart designs that compare the wrong tag, or compare it against the wrong copy, in the kill decisions.

// File: rtl/redir_pkg.sv
package redir_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_DEC  = 2'd1,
    SRC_EXE  = 2'd2
  } redir_src_e;
endpackage

// File: rtl/epoch_match.sv
// Flags an instruction as wrong-path when any of its stamps disagrees
// with the stage's own view of the corresponding epoch.
module epoch_match #(
  parameter int EPOCH_W = 1,
  parameter int NTAG    = 1
) (
  input  logic                    valid,
  input  logic [NTAG*EPOCH_W-1:0] tags,
  input  logic [NTAG*EPOCH_W-1:0] refs,
  output logic                    kill
);
  logic [NTAG-1:0] diff;

  for (genvar g = 0; g < NTAG; g++) begin : g_cmp
    assign diff[g] = tags[g*EPOCH_W +: EPOCH_W] != refs[g*EPOCH_W +: EPOCH_W];
  end

  assign kill = valid && (|diff);
endmodule

// File: rtl/redirect_arbiter.sv
// Execute is older than decode, so its correction always wins.
module redirect_arbiter
  import redir_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            dec_req,
  input  logic            exe_req,
  input  logic [PC_W-1:0] dec_target,
  input  logic [PC_W-1:0] exe_target,
  output redir_src_e      sel,
  output logic [PC_W-1:0] target
);
  always_comb begin
    sel    = SRC_NONE;
    target = dec_target;
    if (exe_req) begin
      sel    = SRC_EXE;
      target = exe_target;
    end else if (dec_req) begin
      sel = SRC_DEC;
    end
  end
endmodule

// File: rtl/epoch_state.sv
// PC and all epoch copies in one register bank, written on the same edge.
module epoch_state
  import redir_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              EPOCH_W  = 1,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter int              STEP     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_en,
  input  redir_src_e         sel,
  input  logic [PC_W-1:0]    target,
  output logic [PC_W-1:0]    pc,
  output logic [EPOCH_W-1:0] fe_epoch,
  output logic [EPOCH_W-1:0] fd_epoch,
  output logic [EPOCH_W-1:0] e_epoch,
  output logic [EPOCH_W-1:0] de_epoch,
  output logic [EPOCH_W-1:0] d_epoch,
  output redir_src_e         src_q
);
  localparam logic [PC_W-1:0]    PC_STEP = PC_W'(STEP);
  localparam logic [EPOCH_W-1:0] EP_ONE  = EPOCH_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= RESET_PC;
      fe_epoch <= '0;
      fd_epoch <= '0;
      e_epoch  <= '0;
      de_epoch <= '0;
      d_epoch  <= '0;
      src_q    <= SRC_NONE;
    end else begin
      src_q <= sel;
      unique case (sel)
        SRC_EXE: begin
          pc       <= target;
          e_epoch  <= e_epoch + EP_ONE;
          fe_epoch <= fe_epoch + EP_ONE;
          de_epoch <= de_epoch + EP_ONE;
        end
        SRC_DEC: begin
          pc       <= target;
          d_epoch  <= d_epoch + EP_ONE;
          fd_epoch <= fd_epoch + EP_ONE;
        end
        default: begin
          if (fetch_en) pc <= pc + PC_STEP;
        end
      endcase
    end
  end
endmodule

// File: rtl/epoch_redirect_ctrl.sv
module epoch_redirect_ctrl
  import redir_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              EPOCH_W  = 1,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000,
  parameter int              STEP     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fetch_en,
  input  logic               dec_valid,
  input  logic               dec_mispredict,
  input  logic [PC_W-1:0]    dec_target,
  input  logic [EPOCH_W-1:0] dec_etag,
  input  logic [EPOCH_W-1:0] dec_dtag,
  input  logic               exe_valid,
  input  logic               exe_mispredict,
  input  logic [PC_W-1:0]    exe_target,
  input  logic [EPOCH_W-1:0] exe_etag,
  output logic [PC_W-1:0]    fetch_pc,
  output logic [EPOCH_W-1:0] fetch_etag,
  output logic [EPOCH_W-1:0] fetch_dtag,
  output logic               dec_kill,
  output logic               exe_kill,
  output logic [1:0]         redir_src
);
  logic [EPOCH_W-1:0] e_epoch, de_epoch, d_epoch;
  redir_src_e         sel, src_q;
  logic [PC_W-1:0]    target;
  logic               dec_req, exe_req;

  epoch_match #(.EPOCH_W(EPOCH_W), .NTAG(2)) u_dec_chk (
    .valid (dec_valid),
    .tags  ({dec_etag, dec_dtag}),
    .refs  ({de_epoch, d_epoch}),
    .kill  (dec_kill)
  );

  epoch_match #(.EPOCH_W(EPOCH_W), .NTAG(1)) u_exe_chk (
    .valid (exe_valid),
    .tags  (exe_etag),
    .refs  (e_epoch),
    .kill  (exe_kill)
  );

  assign exe_req = exe_valid && !exe_kill && exe_mispredict;
  assign dec_req = dec_valid && !dec_kill && dec_mispredict;

  redirect_arbiter #(.PC_W(PC_W)) u_arb (
    .dec_req    (dec_req),
    .exe_req    (exe_req),
    .dec_target (dec_target),
    .exe_target (exe_target),
    .sel        (sel),
    .target     (target)
  );

  epoch_state #(
    .PC_W(PC_W), .EPOCH_W(EPOCH_W), .RESET_PC(RESET_PC), .STEP(STEP)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .fetch_en (fetch_en),
    .sel      (sel),
    .target   (target),
    .pc       (fetch_pc),
    .fe_epoch (fetch_etag),
    .fd_epoch (fetch_dtag),
    .e_epoch  (e_epoch),
    .de_epoch (de_epoch),
    .d_epoch  (d_epoch),
    .src_q    (src_q)
  );

  assign redir_src = src_q;
endmodule

// File: rtl/epoch_redirect_ctrl_chk.sv
module epoch_redirect_ctrl_chk #(
  parameter int              PC_W     = 32,
  parameter int              EPOCH_W  = 1,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_1000,
  parameter int              STEP     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               fetch_en,
  input logic               dec_valid,
  input logic [PC_W-1:0]    dec_target,
  input logic [EPOCH_W-1:0] dec_etag,
  input logic               exe_valid,
  input logic [PC_W-1:0]    exe_target,
  input logic [EPOCH_W-1:0] exe_etag,
  input logic [PC_W-1:0]    fetch_pc,
  input logic [EPOCH_W-1:0] fetch_etag,
  input logic [EPOCH_W-1:0] fetch_dtag,
  input logic               dec_kill,
  input logic               exe_kill,
  input logic [1:0]         redir_src
);
  localparam logic [EPOCH_W-1:0] EP_ONE  = EPOCH_W'(1);
  localparam logic [PC_W-1:0]    PC_STEP = PC_W'(STEP);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_pc == RESET_PC && fetch_etag == '0 &&
                    fetch_dtag == '0 && redir_src == 2'd0));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && redir_src == 2'd0) |->
      fetch_pc == $past(fetch_pc) + ($past(fetch_en) ? PC_STEP : '0));

  // R3
  exe_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    redir_src == 2'd2 |->
      (fetch_pc == $past(exe_target) && fetch_etag == $past(fetch_etag) + EP_ONE));

  // R4
  dec_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    redir_src == 2'd1 |->
      (fetch_pc == $past(dec_target) && fetch_dtag == $past(fetch_dtag) + EP_ONE &&
       $stable(fetch_etag)));

  // R5
  exe_keeps_dtag_chk: assert property (@(posedge clk) disable iff (rst)
    redir_src == 2'd2 |-> $stable(fetch_dtag));

  // R7
  stale_dec_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (redir_src == 2'd2 && dec_valid && dec_etag == $past(fetch_etag)) |-> dec_kill);

  // R9
  exe_stale_kill_chk: assert property (@(posedge clk) disable iff (rst)
    (exe_valid && exe_etag != fetch_etag) |-> exe_kill);
endmodule

bind epoch_redirect_ctrl epoch_redirect_ctrl_chk #(
  .PC_W(PC_W), .EPOCH_W(EPOCH_W), .RESET_PC(RESET_PC), .STEP(STEP)
) u_chk (
  .clk(clk), .rst(rst), .fetch_en(fetch_en),
  .dec_valid(dec_valid), .dec_target(dec_target), .dec_etag(dec_etag),
  .exe_valid(exe_valid), .exe_target(exe_target), .exe_etag(exe_etag),
  .fetch_pc(fetch_pc), .fetch_etag(fetch_etag), .fetch_dtag(fetch_dtag),
  .dec_kill(dec_kill), .exe_kill(exe_kill), .redir_src(redir_src)
);

// File: tb/epoch_redirect_ctrl_bench.sv
module epoch_redirect_ctrl_bench;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en = 1'b0;
  logic        dec_valid = 1'b0, dec_mispredict = 1'b0;
  logic [31:0] dec_target = '0;
  logic [0:0]  dec_etag = '0, dec_dtag = '0;
  logic        exe_valid = 1'b0, exe_mispredict = 1'b0;
  logic [31:0] exe_target = '0;
  logic [0:0]  exe_etag = '0;
  logic [31:0] fetch_pc;
  logic [0:0]  fetch_etag, fetch_dtag;
  logic        dec_kill, exe_kill;
  logic [1:0]  redir_src;

  epoch_redirect_ctrl u_epoch_redirect_ctrl (
    .clk(clk), .rst(rst), .fetch_en(fetch_en),
    .dec_valid(dec_valid), .dec_mispredict(dec_mispredict), .dec_target(dec_target),
    .dec_etag(dec_etag), .dec_dtag(dec_dtag),
    .exe_valid(exe_valid), .exe_mispredict(exe_mispredict), .exe_target(exe_target),
    .exe_etag(exe_etag),
    .fetch_pc(fetch_pc), .fetch_etag(fetch_etag), .fetch_dtag(fetch_dtag),
    .dec_kill(dec_kill), .exe_kill(exe_kill), .redir_src(redir_src)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_pc = RST_PC;
  bit          m_e = 0, m_d = 0;
  int          m_src = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare registered outputs with the model; called just after a negedge.
  task automatic check_regs(string req);
    chk(req, "fetch_pc", fetch_pc, m_pc);
    chk(req, "fetch_etag", fetch_etag, m_e);
    chk(req, "fetch_dtag", fetch_dtag, m_d);
    chk(req, "redir_src", redir_src, m_src);
  endtask

  // One cycle: check state, apply inputs, check kills, advance the model.
  task automatic step(string req, bit fen,
                      bit dv, bit dm, logic [31:0] dt, bit det, bit ddt,
                      bit xv, bit xm, logic [31:0] xt, bit xet);
    bit dk, xk, xacc, dacc;
    @(negedge clk);
    check_regs(req);
    fetch_en = fen;
    dec_valid = dv; dec_mispredict = dm; dec_target = dt;
    dec_etag = det; dec_dtag = ddt;
    exe_valid = xv; exe_mispredict = xm; exe_target = xt; exe_etag = xet;
    #1;
    dk = dv && (det != m_e || ddt != m_d);
    xk = xv && (xet != m_e);
    chk(req, "dec_kill", dec_kill, dk);
    chk(req, "exe_kill", exe_kill, xk);
    xacc = xv && !xk && xm;
    dacc = dv && !dk && dm && !xacc;
    if (xacc) begin
      m_pc = xt; m_e = !m_e; m_src = 2;
    end else if (dacc) begin
      m_pc = dt; m_d = !m_d; m_src = 1;
    end else begin
      if (fen) m_pc = m_pc + 32'd4;
      m_src = 0;
    end
  endtask

  task automatic idle(string req, bit fen);
    step(req, fen, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_regs("R1");          // during reset
    rst = 1'b0;
    // R1: first cycle after reset
    idle("R1", 1);
    // R2: sequential fetch and stall
    idle("R2", 1);
    idle("R2", 0);
    idle("R2", 0);
    idle("R2", 1);
    // R3: execute redirect
    step("R3", 1, 0, 0, 0, 0, 0, 1, 1, 32'h0000_2000, m_e);
    idle("R3", 1);
    // R4: decode redirect
    step("R4", 1, 1, 1, 32'h0000_3000, m_e, m_d, 0, 0, 0, 0);
    idle("R4", 1);
    // R5: both in one cycle
    step("R5", 1, 1, 1, 32'h0000_4400, m_e, m_d, 1, 1, 32'h0000_4000, m_e);
    idle("R5", 1);
    // R7: execute, then decode holding the old execute stamp
    step("R7", 1, 0, 0, 0, 0, 0, 1, 1, 32'h0000_5000, m_e);
    step("R7", 1, 1, 1, 32'h0000_5500, !m_e, m_d, 0, 0, 0, 0);
    idle("R7", 1);
    // R6: stale decode stamp ignored
    step("R6", 1, 1, 1, 32'h0000_6600, m_e, !m_d, 0, 0, 0, 0);
    idle("R6", 1);
    // R8: decode, then execute one cycle later
    step("R8", 1, 1, 1, 32'h0000_7700, m_e, m_d, 0, 0, 0, 0);
    step("R8", 1, 0, 0, 0, 0, 0, 1, 1, 32'h0000_7000, m_e);
    idle("R8", 1);
    // R9: stale execute stamp ignored
    step("R9", 1, 0, 0, 0, 0, 0, 1, 1, 32'h0000_8000, !m_e);
    idle("R9", 1);
    // R10: redirects while fetch is stalled
    step("R10", 0, 0, 0, 0, 0, 0, 1, 1, 32'h0000_9000, m_e);
    step("R10", 0, 1, 1, 32'h0000_9900, m_e, m_d, 0, 0, 0, 0);
    idle("R10", 0);
    // R6: mixed traffic with current and stale stamps
    for (int i = 0; i < 400; i++) begin
      step("R6", 1'($urandom % 4 != 0),
           1'($urandom), 1'($urandom % 3 == 0), $urandom & 32'hFFFC,
           ($urandom % 4 == 0) ? !m_e : m_e, ($urandom % 4 == 0) ? !m_d : m_d,
           1'($urandom), 1'($urandom % 4 == 0), $urandom & 32'hFFFC,
           ($urandom % 4 == 0) ? !m_e : m_e);
    end
    idle("R2", 0);
    @(negedge clk);
    check_regs("R2");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule